// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block translates 32-bit virtual addresses into physical addresses. It uses a small, fully associative table of page translations. Each slot stores a valid flag, a virtual page number, an address-space tag and a physical frame number. Each lookup compares against the tag in a current-space register as well as the page number. Several tasks can therefore keep translations for the same virtual page in the table at the same time. Software only reloads the current-space register on a task switch and does not flush the table.

A request presents a virtual address. One clock later the block returns hit or miss and the physical address. The physical address is the frame number joined with the untouched 12-bit page offset, and it is the address a physically tagged cache compares against. Software fills slots by index through a write port. A single-cycle global invalidate drops every translation at once. Miss handling and table walking belong to the surrounding logic.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is invalid, the current-space register reads zero, and both `rsp_hit` and `rsp_miss` are low.
- R2: A lookup hits only when a valid slot holds both the requested virtual page number (address bits 31:12) and the current-space register value. A slot that matches on only one of the two does not hit.
- R3: On a hit, `rsp_paddr` equals the slot's 20-bit frame number in bits 31:12, with request address bits 11:0 copied unchanged into bits 11:0.
- R4: Slots with the same page number and different space tags are valid at the same time. The current-space value alone decides which of them translates.
- R5: A write to the current-space register takes effect on the next cycle. A lookup issued in the same cycle as the write uses the old value.
- R6: Results are registered. A request in cycle N sets exactly one of `rsp_hit` or `rsp_miss` in cycle N+1. A cycle with no request is followed by both being low.
- R7: A slot write replaces all four fields of that slot. Writing with `wr_valid` low removes the old translation, and a rewritten slot no longer matches its old page.
- R8: When more than one valid slot matches, the one with the lowest index supplies the frame number.
- R9: `flush_all` invalidates every slot in one cycle. It takes priority over a slot write in the same cycle and leaves the current-space register unchanged.
- R10: On a miss, `rsp_hit` is low and `rsp_paddr` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| rsp_hit | output | 1 | Registered hit result |
| rsp_miss | output | 1 | Registered miss result |
| rsp_paddr | output | 32 | Registered physical address (zero on miss) |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 4 | Slot index to write |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_asid | input | 8 | Space tag to store |
| wr_pfn | input | 20 | Frame number to store |
| wr_valid | input | 1 | Valid flag to store |
| asid_we | input | 1 | Current-space register write strobe |
| asid_wdata | input | 8 | New current-space value |
| asid_cur | output | 8 | Current-space register value |
| flush_all | input | 1 | Invalidate all slots |

## Verification
The main lookup path is tested with several address patterns. A plain match is used against a same-page request from a different space, which separates a page-only compare from a full-key compare. Two slots share a page under different tags, which shows that switching the space register re-targets lookups without any flush. Duplicate keys in a low and a high slot expose the selection order. A space write issued in the same cycle as a lookup shows which register value the compare uses. A flush issued in the same cycle as a slot write shows which of the two wins.

// File: rtl/tlb_cfg_pkg.sv
package tlb_cfg_pkg;
  localparam int unsigned DEF_VA_W      = 32;
  localparam int unsigned DEF_PAGE_BITS = 12;
  localparam int unsigned DEF_ENTRIES   = 16;
  localparam int unsigned DEF_ASID_W    = 8;
  localparam int unsigned DEF_PFN_W     = 20;
endpackage

// File: rtl/tlb_asid_reg.sv
module tlb_asid_reg #(
  parameter int unsigned ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ASID_W-1:0] wdata,
  output logic [ASID_W-1:0] cur
);
  logic [ASID_W-1:0] cur_q, cur_d;

  always_comb begin
    cur_d = cur_q;
    if (we) cur_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else if (we) cur_q <= cur_d;
  end

  assign cur = cur_q;
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned PFN_W   = 20,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [VPN_W-1:0]         wr_vpn,
  input  logic [ASID_W-1:0]        wr_asid,
  input  logic [PFN_W-1:0]         wr_pfn,
  input  logic                     wr_valid,
  input  logic [VPN_W-1:0]         look_vpn,
  input  logic [ASID_W-1:0]        look_asid,
  output logic [ENTRIES-1:0]       match_vec,
  output logic [ENTRIES*PFN_W-1:0] pfn_flat
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic              vld_q, vld_d, vld_en;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    logic [PFN_W-1:0]  pfn_q;
    logic              sel;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    // flush outranks a same-cycle slot write
    always_comb begin
      vld_en = flush | sel;
      vld_d  = vld_q;
      if (flush)    vld_d = 1'b0;
      else if (sel) vld_d = wr_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else if (vld_en) vld_q <= vld_d;
    end

    // payload fields carry no reset; the valid flag guards them
    always_ff @(posedge clk) begin
      if (sel && !flush) begin
        vpn_q  <= wr_vpn;
        asid_q <= wr_asid;
        pfn_q  <= wr_pfn;
      end
    end

    assign match_vec[g] = vld_q && (vpn_q == look_vpn) && (asid_q == look_asid);
    assign pfn_flat[g*PFN_W +: PFN_W] = pfn_q;
  end
endmodule

// File: rtl/tlb_prio_select.sv
module tlb_prio_select #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned PFN_W   = 20
) (
  input  logic [ENTRIES-1:0]       match_vec,
  input  logic [ENTRIES*PFN_W-1:0] pfn_flat,
  output logic                     any_hit,
  output logic [PFN_W-1:0]         sel_pfn
);
  // descending scan: the last assignment, from the lowest match, wins
  always_comb begin
    sel_pfn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) sel_pfn = pfn_flat[i*PFN_W +: PFN_W];
    end
  end

  assign any_hit = |match_vec;
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_cfg_pkg::*;
#(
  parameter int unsigned VA_W      = DEF_VA_W,
  parameter int unsigned PAGE_BITS = DEF_PAGE_BITS,
  parameter int unsigned ENTRIES   = DEF_ENTRIES,
  parameter int unsigned ASID_W    = DEF_ASID_W,
  parameter int unsigned PFN_W     = DEF_PFN_W,
  localparam int unsigned VPN_W    = VA_W - PAGE_BITS,
  localparam int unsigned PA_W     = PFN_W + PAGE_BITS,
  localparam int unsigned IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [PA_W-1:0]   rsp_paddr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_valid,
  input  logic              asid_we,
  input  logic [ASID_W-1:0] asid_wdata,
  output logic [ASID_W-1:0] asid_cur,
  input  logic              flush_all
);
  logic [ENTRIES-1:0]       match_vec;
  logic [ENTRIES*PFN_W-1:0] pfn_flat;
  logic                     any_hit;
  logic [PFN_W-1:0]         sel_pfn;

  tlb_asid_reg #(.ASID_W(ASID_W)) u_asid (
    .clk(clk), .rst_n(rst_n), .we(asid_we), .wdata(asid_wdata), .cur(asid_cur)
  );

  tlb_entry_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .flush(flush_all),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
    .wr_pfn(wr_pfn), .wr_valid(wr_valid),
    .look_vpn(lk_vaddr[VA_W-1:PAGE_BITS]), .look_asid(asid_cur),
    .match_vec(match_vec), .pfn_flat(pfn_flat)
  );

  tlb_prio_select #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_sel (
    .match_vec(match_vec), .pfn_flat(pfn_flat),
    .any_hit(any_hit), .sel_pfn(sel_pfn)
  );

  logic            hit_q, hit_d, miss_q, miss_d;
  logic [PA_W-1:0] pa_q, pa_d;

  always_comb begin
    hit_d  = lk_valid & any_hit;
    miss_d = lk_valid & ~any_hit;
    pa_d   = hit_d ? {sel_pfn, lk_vaddr[PAGE_BITS-1:0]} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      miss_q <= 1'b0;
      pa_q   <= '0;
    end else begin
      hit_q  <= hit_d;
      miss_q <= miss_d;
      pa_q   <= pa_d;
    end
  end

  assign rsp_hit   = hit_q;
  assign rsp_miss  = miss_q;
  assign rsp_paddr = pa_q;
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned ASID_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 lk_valid,
  input logic [PAGE_BITS-1:0] lk_off,
  input logic                 flush_all,
  input logic                 asid_we,
  input logic [ASID_W-1:0]    asid_wdata,
  input logic [ASID_W-1:0]    asid_cur,
  input logic                 rsp_hit,
  input logic                 rsp_miss,
  input logic [PA_W-1:0]      rsp_paddr
);
  // R6
  req_gives_one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (rsp_hit ^ rsp_miss));
  // R6
  idle_gives_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_hit && !rsp_miss));
  // R3
  offset_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!rsp_hit || rsp_paddr[PAGE_BITS-1:0] == $past(lk_off)));
  // R10
  miss_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (!rsp_hit && rsp_paddr == '0));
  // R5
  asid_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asid_we |=> (asid_cur == $past(asid_wdata)));
  // R9
  flush_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !asid_we) |=> (asid_cur == $past(asid_cur)));
  // R9
  post_flush_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && $past(flush_all)) |=> rsp_miss);
endmodule

bind asid_tlb asid_tlb_chk #(.PAGE_BITS(PAGE_BITS), .PA_W(PA_W), .ASID_W(ASID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_off(lk_vaddr[PAGE_BITS-1:0]),
  .flush_all(flush_all), .asid_we(asid_we), .asid_wdata(asid_wdata),
  .asid_cur(asid_cur), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr)
);

// File: tb/asid_tlb_test.sv
module asid_tlb_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic        rsp_hit, rsp_miss;
  logic [31:0] rsp_paddr;
  logic        wr_en, wr_valid;
  logic [3:0]  wr_idx;
  logic [19:0] wr_vpn, wr_pfn;
  logic [7:0]  wr_asid, asid_wdata, asid_cur;
  logic        asid_we, flush_all;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
    .wr_pfn(wr_pfn), .wr_valid(wr_valid), .asid_we(asid_we),
    .asid_wdata(asid_wdata), .asid_cur(asid_cur), .flush_all(flush_all)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_slot(input int idx, input logic [19:0] vpn, input logic [7:0] tag,
                         input logic [19:0] pfn, input logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx[3:0]; wr_vpn = vpn; wr_asid = tag; wr_pfn = pfn; wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_space(input logic [7:0] tag);
    @(negedge clk);
    asid_we = 1'b1; asid_wdata = tag;
    @(negedge clk);
    asid_we = 1'b0;
  endtask

  // request at a negedge, result sampled at the following negedge
  task automatic look(input string req, input logic [31:0] va,
                      input logic exp_hit, input logic [31:0] exp_pa);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va;
    @(negedge clk);
    lk_valid = 1'b0;
    check(req, {62'd0, rsp_hit, rsp_miss}, {62'd0, exp_hit, ~exp_hit});
    check(req, {32'd0, rsp_paddr}, {32'd0, exp_pa});
  endtask

  task automatic t_reset;
    check("R1 space reg", {56'd0, asid_cur}, 64'd0);
    check("R1 outputs idle", {62'd0, rsp_hit, rsp_miss}, 64'd0);
    look("R1 empty table miss", 32'h0000_0123, 1'b0, 32'h0);
  endtask

  task automatic t_basic;
    wr_slot(3, 20'h12345, 8'h00, 20'h00ABC, 1'b1);
    look("R2 R3 plain hit", 32'h1234_5678, 1'b1, 32'h00AB_C678);
    look("R10 other page miss", 32'h1234_6678, 1'b0, 32'h0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = 32'h1234_5FFF;
    #1;
    check("R6 not combinational", {62'd0, rsp_hit, rsp_miss}, 64'd0);
    @(negedge clk);
    lk_valid = 1'b0;
    check("R6 one cycle later", {62'd0, rsp_hit, rsp_miss}, 64'd2);
    check("R3 offset kept", {32'd0, rsp_paddr}, 64'h00AB_CFFF);
    @(negedge clk);
    check("R6 idle after idle", {62'd0, rsp_hit, rsp_miss}, 64'd0);
  endtask

  task automatic t_space;
    wr_slot(5, 20'h12345, 8'h07, 20'h55555, 1'b1);
    look("R4 space 0 view", 32'h1234_5010, 1'b1, 32'h00AB_C010);
    set_space(8'h07);
    check("R5 space loaded", {56'd0, asid_cur}, 64'h07);
    look("R4 space 7 view", 32'h1234_5010, 1'b1, 32'h5555_5010);
    // space write and lookup in the same cycle: old space (7) applies
    @(negedge clk);
    asid_we = 1'b1; asid_wdata = 8'h00; lk_valid = 1'b1; lk_vaddr = 32'h1234_5020;
    @(negedge clk);
    asid_we = 1'b0; lk_valid = 1'b0;
    check("R5 old space used", {32'd0, rsp_paddr}, 64'h5555_5020);
    look("R5 new space used", 32'h1234_5020, 1'b1, 32'h00AB_C020);
    set_space(8'h09);
    look("R2 tag mismatch miss", 32'h1234_5020, 1'b0, 32'h0);
    set_space(8'h00);
  endtask

  task automatic t_dup;
    wr_slot(9, 20'h00077, 8'h00, 20'h99999, 1'b1);
    wr_slot(1, 20'h00077, 8'h00, 20'h11111, 1'b1);
    look("R8 lowest slot wins", 32'h0007_7ABC, 1'b1, 32'h1111_1ABC);
    wr_slot(1, 20'h00077, 8'h00, 20'h11111, 1'b0);
    look("R7 invalidated slot gone", 32'h0007_7ABC, 1'b1, 32'h9999_9ABC);
    wr_slot(9, 20'h00078, 8'h00, 20'h22222, 1'b1);
    look("R7 old page dropped", 32'h0007_7ABC, 1'b0, 32'h0);
    look("R7 new page live", 32'h0007_8ABC, 1'b1, 32'h2222_2ABC);
  endtask

  task automatic t_flush;
    set_space(8'h07);
    @(negedge clk);
    flush_all = 1'b1;
    wr_en = 1'b1; wr_idx = 4'd0; wr_vpn = 20'hABCDE; wr_asid = 8'h07;
    wr_pfn = 20'h33333; wr_valid = 1'b1;
    @(negedge clk);
    flush_all = 1'b0; wr_en = 1'b0;
    check("R9 space kept", {56'd0, asid_cur}, 64'h07);
    look("R9 flushed slot 5", 32'h1234_5000, 1'b0, 32'h0);
    look("R9 write lost to flush", 32'hABCD_E000, 1'b0, 32'h0);
    set_space(8'h00);
    look("R9 flushed slot 3", 32'h1234_5000, 1'b0, 32'h0);
    look("R9 flushed slot 9", 32'h0007_8000, 1'b0, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = '0;
    wr_en = 1'b0; wr_idx = '0; wr_vpn = '0; wr_asid = '0; wr_pfn = '0; wr_valid = 1'b0;
    asid_we = 1'b0; asid_wdata = '0; flush_all = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_latency();
    t_space();
    t_dup();
    t_flush();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule